// File: doc/BRIEF.md
# Eight-Level Row-Scan PWM Dimmer

This block sets the refresh timing and the internal brightness of a 5 x 7 dot-matrix character display. Each clock cycle is one sub-slot. A group of `SLOTS` sub-slots (32 by default) makes one row period, and `ROWS` row periods (7 by default) make one frame. The block reports which row is being driven. It raises a row-enable window at the start of every row period and holds it for a number of sub-slots taken from a 3-bit brightness code. The eight codes follow a roughly logarithmic scale. Code 000 is the brightest and code 111 is the dimmest.

The block also produces a cursor enable at half brightness for the row drivers. It is the row window cut to its first half. A single disable input turns the internal dimming off, and the display then runs at full duty. Dimming from outside the block, for example a PWM signal on a blank pin, is applied downstream and is not handled here.

The sequencer is a three-state machine:
- S_SYNC is the reset state. The scan is held, every output is low, and the brightness inputs are captured.
- S_ON is the window part of a row.
- S_OFF is the dark rest of the row.

The transitions are:
- SYNC_TO_ON on the first clock after reset.
- ON_TO_OFF when the next slot reaches the on-slot count.
- OFF_TO_ON or ON_TO_ON on the last slot of every row.

Top module: `row_pwm_dimmer`

## Requirements
- R1: While `rst_n` is low, `row_idx` is 0 and `row_en`, `cursor_en` and `frame_start` are all 0. The first clock edge with `rst_n` high starts row 0 at sub-slot 0.
- R2: Every row period lasts exactly `SLOTS` cycles. `row_idx` steps 0, 1, ..., `ROWS`-1 and then wraps back to 0, changing only at a row boundary.
- R3: `frame_start` is high for exactly one cycle, the first cycle of row 0, and at no other time.
- R4: When `ext_fn_dis` is 0, `row_en` is high for the first N cycles of the row period and low for the rest. For `SLOTS`=32, N is set by `bright_code` (binary) as follows: 000→32, 001→19, 010→13, 011→9, 100→5, 101→3, 110→2, 111→1.
- R5: When `ext_fn_dis` is 1, the brightness code is ignored and `row_en` is high for all `SLOTS` cycles of the row.
- R6: `cursor_en` is high only while `row_en` is high. It covers the first ceil(N/2) cycles of the row: 16, 10, 7, 5, 3, 2, 1 and 1 for codes 000 to 111, and 16 when `ext_fn_dis` is 1.
- R7: A row uses the `bright_code` and `ext_fn_dis` values present at two clock edges:
  - For row 0 after reset, the values at the first clock edge after reset.
  - For every other row, the values at the clock edge that ends the last sub-slot of the preceding row.

  Changes at any other time have no effect on the row in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one sub-slot |
| rst_n | input | 1 | Active-low synchronous reset |
| bright_code | input | 3 | Brightness code, 000 brightest, 111 dimmest |
| ext_fn_dis | input | 1 | 1 forces full duty and ignores the code |
| row_idx | output | 3 | Row being driven, 0 to ROWS-1 |
| row_en | output | 1 | Row drive window |
| cursor_en | output | 1 | Half-duty window for the cursor pattern |
| frame_start | output | 1 | One-cycle pulse at the start of row 0 |

## Verification
Two events can land in the same cycle, and they are tested together:
- the row advance, together with the capture of the next brightness setting;
- a new brightness code being driven on the bus.

To provoke this, the bench drives the next row's code in the last sub-slot of every row. It also drives a different, glitch code in the middle of the row. The row is judged correct only if its whole on-window and cursor window match the code from the last sub-slot and ignore the glitch code. Every seventh row also checks that the row wrap and `frame_start` coincide at sub-slot 0.

// File: rtl/dim_pkg.sv
package dim_pkg;

    typedef enum logic [1:0] {
        S_SYNC = 2'd0,
        S_ON   = 2'd1,
        S_OFF  = 2'd2
    } scan_state_t;

    // Nominal duty in percent for each brightness code.
    function automatic int duty_pct(input int code);
        case (code)
            0:       return 100;
            1:       return 60;
            2:       return 40;
            3:       return 27;
            4:       return 17;
            5:       return 10;
            6:       return 7;
            default: return 3;
        endcase
    endfunction

    // On-slot count: nearest integer to slots*pct/100, at least one.
    function automatic int on_slots(input int slots, input int code);
        int v;
        v = (slots * duty_pct(code) + 50) / 100;
        if (v < 1)     v = 1;
        if (v > slots) v = slots;
        return v;
    endfunction

endpackage

// File: rtl/dim_lut.sv
module dim_lut
    import dim_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int NW   = $clog2(SLOTS + 1)
) (
    input  logic [2:0]    code,
    input  logic          efd,
    output logic [NW-1:0] on_cnt,
    output logic [NW-1:0] half_cnt
);
    logic [NW-1:0] tbl [8];

    genvar g;
    generate
        for (g = 0; g < 8; g++) begin : g_tbl
            assign tbl[g] = NW'(on_slots(SLOTS, g));
        end
    endgenerate

    logic [2:0]  eff_code;
    logic [NW:0] sum;

    always_comb begin
        eff_code = efd ? 3'd0 : code;
        on_cnt   = tbl[eff_code];
        sum      = {1'b0, on_cnt} + 1'b1;
        half_cnt = sum[NW:1];
    end
endmodule

// File: rtl/dim_scan.sv
module dim_scan #(
    parameter int SLOTS = 32,
    parameter int ROWS  = 7,
    localparam int SW   = $clog2(SLOTS),
    localparam int RW   = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [SW-1:0] slot,
    output logic [RW-1:0] row,
    output logic          row_last
);
    localparam logic [SW-1:0] SLOT_MAX = SW'(SLOTS - 1);
    localparam logic [RW-1:0] ROW_MAX  = RW'(ROWS - 1);

    assign row_last = run && (slot == SLOT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
            row  <= '0;
        end else if (run) begin
            if (slot == SLOT_MAX) begin
                slot <= '0;
                row  <= (row == ROW_MAX) ? '0 : row + 1'b1;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end
endmodule

// File: rtl/row_pwm_dimmer.sv
module row_pwm_dimmer
    import dim_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int ROWS  = 7,
    localparam int SW   = $clog2(SLOTS),
    localparam int RW   = $clog2(ROWS),
    localparam int NW   = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    bright_code,
    input  logic          ext_fn_dis,
    output logic [RW-1:0] row_idx,
    output logic          row_en,
    output logic          cursor_en,
    output logic          frame_start
);
    scan_state_t   state_q, state_d;
    logic [SW-1:0] slot_w;
    logic [RW-1:0] row_w;
    logic          row_last;
    logic [NW-1:0] on_new, half_new;
    logic [NW-1:0] on_q, half_q;
    logic          run;

    assign run = (state_q != S_SYNC);

    dim_scan #(.SLOTS(SLOTS), .ROWS(ROWS)) u_scan (
        .clk(clk), .rst_n(rst_n), .run(run),
        .slot(slot_w), .row(row_w), .row_last(row_last)
    );

    dim_lut #(.SLOTS(SLOTS)) u_lut (
        .code(bright_code), .efd(ext_fn_dis),
        .on_cnt(on_new), .half_cnt(half_new)
    );

    // State register and per-row capture of the brightness setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_SYNC;
            on_q    <= '0;
            half_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_SYNC || row_last) begin
                on_q   <= on_new;
                half_q <= half_new;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_SYNC: state_d = S_ON;
            S_ON: begin
                if (row_last)
                    state_d = S_ON;
                else if (({1'b0, slot_w} + 1'b1) >= {1'b0, on_q})
                    state_d = S_OFF;
            end
            S_OFF: if (row_last) state_d = S_ON;
            default: state_d = S_SYNC;
        endcase
    end

    // Outputs.
    always_comb begin
        row_idx     = row_w;
        row_en      = (state_q == S_ON);
        cursor_en   = row_en && ({1'b0, slot_w} < {1'b0, half_q});
        frame_start = run && (slot_w == '0) && (row_w == '0);
    end
endmodule

// File: rtl/dim_chk.sv
module dim_chk #(
    parameter int SLOTS = 32,
    parameter int ROWS  = 7,
    localparam int SW   = $clog2(SLOTS),
    localparam int RW   = $clog2(ROWS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [RW-1:0] row_idx,
    input logic          row_en,
    input logic          cursor_en,
    input logic          frame_start,
    input logic [SW-1:0] slot
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (row_idx == '0)) else $error("reset row"); // R1

    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(row_idx) < ROWS); // R2

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_idx) |-> ((slot == '0) &&
            ((int'(row_idx) == int'($past(row_idx)) + 1) ||
             (row_idx == '0 && int'($past(row_idx)) == ROWS - 1)))); // R2

    AST_FRAME_AT_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (row_idx == '0 && slot == '0 && row_en)); // R3

    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R3

    AST_EN_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_en) |-> (slot == '0)); // R4

    AST_CURSOR_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        cursor_en |-> row_en); // R6

    AST_CURSOR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cursor_en) |-> (slot == '0)); // R6
endmodule

bind row_pwm_dimmer dim_chk #(.SLOTS(SLOTS), .ROWS(ROWS)) u_chk (
    .clk(clk), .rst_n(rst_n), .row_idx(row_idx), .row_en(row_en),
    .cursor_en(cursor_en), .frame_start(frame_start), .slot(slot_w)
);

// File: tb/sim_row_pwm_dimmer.sv
module sim_row_pwm_dimmer;
    localparam int SLOTS = 32;
    localparam int ROWS  = 7;
    localparam int NROWS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bright_code = 3'd0;
    logic       ext_fn_dis = 1'b0;
    logic [2:0] row_idx;
    logic       row_en, cursor_en, frame_start;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        int row;
        int on;
        int half;
        int code;
        int efd;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    row_pwm_dimmer #(.SLOTS(SLOTS), .ROWS(ROWS)) u0 (
        .clk(clk), .rst_n(rst_n), .bright_code(bright_code),
        .ext_fn_dis(ext_fn_dis), .row_idx(row_idx), .row_en(row_en),
        .cursor_en(cursor_en), .frame_start(frame_start)
    );

    function automatic int exp_on(input int code, input int efd);
        int t[8] = '{32, 19, 13, 9, 5, 3, 2, 1};
        return efd ? 32 : t[code];
    endfunction

    task automatic check(input string req, input int act, input int expv, input string what);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Driver: set the setting for a row and push what that row must show.
    task automatic drive_row(input int rowno, input int code, input int efd);
        exp_t e;
        bright_code = 3'(code);
        ext_fn_dis  = efd[0];
        e.row  = rowno % ROWS;
        e.on   = exp_on(code, efd);
        e.half = (e.on + 1) / 2;
        e.code = code;
        e.efd  = efd;
        q.push_back(e);
    endtask

    int codes [NROWS] = '{3, 0, 1, 2, 3, 4, 5, 6, 7, 5, 7, 1, 0, 6, 2, 4};
    int efds  [NROWS] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 1, 0, 0, 0};

    initial begin
        repeat (3) begin
            @(negedge clk);
            check("R1", row_idx, 0, "row_idx in reset");
            check("R1", {row_en, cursor_en, frame_start}, 0, "outputs in reset");
        end
        drive_row(0, codes[0], efds[0]);
        rst_n = 1'b1;
        @(posedge clk);
        for (int k = 1; k < NROWS; k++) begin
            repeat (10) @(negedge clk);
            // Mid-row glitch code: must not affect the current row (R7).
            bright_code = ~3'(codes[k - 1]);
            ext_fn_dis  = ~efds[k - 1][0];
            repeat (22) @(negedge clk);
            drive_row(k, codes[k], efds[k]);
        end
    end

    // Monitor: gather one row period, then compare against the queue head.
    initial begin
        exp_t e;
        int on_err, cur_err, fs_err, row_err, on_cnt, cur_cnt;
        @(posedge rst_n);
        @(posedge clk);
        for (int r = 0; r < NROWS; r++) begin
            on_err = 0; cur_err = 0; fs_err = 0; row_err = 0;
            on_cnt = 0; cur_cnt = 0;
            e = q[0];
            for (int s = 0; s < SLOTS; s++) begin
                @(negedge clk);
                if (int'(row_idx) != e.row) row_err++;
                if (row_en != (s < e.on)) on_err++;
                if (cursor_en != (s < e.half)) cur_err++;
                if (frame_start != (s == 0 && e.row == 0)) fs_err++;
                on_cnt  += int'(row_en);
                cur_cnt += int'(cursor_en);
            end
            void'(q.pop_front());
            check("R2", row_err, 0, $sformatf("row %0d index mismatches", r));
            check("R3", fs_err, 0, $sformatf("row %0d frame_start mismatches", r));
            if (e.efd != 0)
                check("R5", on_cnt, e.on, $sformatf("row %0d on-slots efd=1 code=%0d", r, e.code));
            else
                check("R4", on_cnt, e.on, $sformatf("row %0d on-slots code=%0d", r, e.code));
            check("R4", on_err, 0, $sformatf("row %0d window shape", r));
            check("R6", cur_cnt, e.half, $sformatf("row %0d cursor slots", r));
            check("R6", cur_err, 0, $sformatf("row %0d cursor shape", r));
            if (r > 0)
                check("R7", on_cnt + 100 * cur_cnt, e.on + 100 * e.half,
                      $sformatf("row %0d setting taken at row boundary", r));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule